// File: doc/BRIEF.md
# Memory-Mapped Text Console and Keyboard Port

This block is a slave on a simple CPU byte bus. It combines two devices in one address window. The first is a character buffer for a text screen. The CPU stores characters in it with ordinary byte writes, and display hardware fetches them through a second read port that runs on its own. The screen is 24 rows of 80 columns, placed at byte address 0xF000. The character at row r and column c sits at offset r*80+c.

The second device is a keyboard data port made of two byte registers. A key-press strobe from the keyboard logic puts its character code into the code register at 0xF801. The same strobe sets the flag register at 0xF800 to 0x01. Software polls the flag, reads the code, and acknowledges the key by writing 0x00 to the flag. No interrupt is involved.

CPU reads are synchronous. The byte appears on the read-data port in the cycle after the read enable, and the port shows 0x00 when the previous cycle was not a read.

Top module: `console_mmio`

## Requirements
- R1: A CPU write to address 0xF000+row*80+col (rows 0..23, columns 0..79) stores the byte. The display port returns it one cycle after that cell index (row*80+col) is presented.
- R2: A CPU read of any buffer address returns the stored byte on the read-data port in the cycle after the read enable.
- R3: When a CPU write and a read of the same cell (from the display port, the CPU port, or both) happen in the same cycle, the read returns the old contents. The new byte is visible from the next access on.
- R4: A key-press strobe loads its code into the code register (0xF801) and makes the flag register (0xF800) read 0x01.
- R5: A CPU write of 0x00 to 0xF800 clears the flag. A nonzero write to 0xF800 has no effect, and a write to 0xF801 has no effect.
- R6: If a strobe and a flag-clear write fall in the same cycle, the flag ends at 0x01 and the code register holds the new code.
- R7: A strobe while the flag is already 0x01 replaces the code, and the flag stays 0x01.
- R8: CPU reads of addresses outside 0xF000..0xF77F and 0xF800..0xF801 return 0x00. CPU writes to those addresses change neither buffer nor keyboard registers. Display indices of 1920 and above return 0x00.
- R9: The read-data port is 0x00 in any cycle that follows a cycle without read enable.
- R10: After reset, both the flag and the code register read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_addr | input | 16 | CPU byte address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | CPU write enable |
| bus_re | input | 1 | CPU read enable |
| bus_rdata | output | 8 | CPU read data, one cycle after the read enable |
| key_strobe | input | 1 | One-cycle key-press pulse |
| key_code | input | 8 | Character code that goes with the strobe |
| disp_addr | input | 11 | Display-side cell index (row*80+col) |
| disp_rdata | output | 8 | Display-side character, one cycle after the index |

## Verification
The hardest cases to reach are the ones where two sides act in the same clock edge. One is a key strobe landing together with the CPU's clear write. The other is a CPU write hitting the very cell that the display port and the CPU port are reading. The bench drives every signal of each such pair on the same falling edge, so both requests reach the same rising edge. It then compares the next values with results worked out from the rules above. Beyond those cases, the bench sweeps all 1920 cells with a computed pattern and all 256 key codes through the full set-and-acknowledge cycle.

// File: rtl/console_pkg.sv
package console_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TEXT = 2'd1,
    SRC_KBD  = 2'd2
  } rd_src_e;

endpackage

// File: rtl/console_rst_sync.sv
module console_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/console_addr_dec.sv
module console_addr_dec #(
  parameter int ADDR_W    = 16,
  parameter int FB_DEPTH  = 1920,
  parameter int IDX_W     = 11,
  parameter logic [ADDR_W-1:0] FB_BASE   = 16'hF000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF800,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 16'hF801
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              fb_hit,
  output logic [IDX_W-1:0]  fb_idx,
  output logic              stat_hit,
  output logic              code_hit
);

  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(FB_DEPTH);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = addr - FB_BASE;
    fb_hit   = (addr >= FB_BASE) && (offset < DEPTH_A);
    fb_idx   = offset[IDX_W-1:0];
    stat_hit = (addr == STAT_ADDR);
    code_hit = (addr == CODE_ADDR);
  end

endmodule

// File: rtl/console_text_ram.sv
module console_text_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1920,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_rd_en,
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic [DATA_W-1:0] cpu_q,
  input  logic              dsp_rd_en,
  input  logic [IDX_W-1:0]  dsp_idx,
  output logic [DATA_W-1:0] dsp_q
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_rd_en) begin
      cpu_q <= cells[cpu_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (dsp_rd_en) begin
      dsp_q <= cells[dsp_idx];
    end
  end

endmodule

// File: rtl/console_kbd_regs.sv
module console_kbd_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              strobe,
  input  logic [DATA_W-1:0] code_in,
  input  logic              clr_req,
  output logic              flag_q,
  output logic [DATA_W-1:0] code_q
);

  logic              flag_d;
  logic              flag_en;
  logic [DATA_W-1:0] code_d;
  logic              code_en;

  // a new key takes priority over the acknowledge write
  always_comb begin
    flag_en = strobe | clr_req;
    flag_d  = strobe;
    code_en = strobe;
    code_d  = code_in;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/console_mmio.sv
module console_mmio #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int FB_COLS = 80,
  parameter int FB_ROWS = 24,
  parameter logic [ADDR_W-1:0] FB_BASE   = 16'hF000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF800,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 16'hF801,
  localparam int FB_DEPTH = FB_COLS * FB_ROWS,
  localparam int IDX_W    = $clog2(FB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_strobe,
  input  logic [DATA_W-1:0] key_code,
  input  logic [IDX_W-1:0]  disp_addr,
  output logic [DATA_W-1:0] disp_rdata
);

  import console_pkg::*;

  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(FB_DEPTH);

  logic              rst_ns;
  logic              fb_hit;
  logic [IDX_W-1:0]  fb_idx;
  logic              stat_hit;
  logic              code_hit;
  logic              fb_wr;
  logic              fb_rd;
  logic              kbd_clr;
  logic              kbd_stat;
  logic [DATA_W-1:0] kbd_code;
  logic [DATA_W-1:0] text_q;
  logic [DATA_W-1:0] dsp_q;
  logic              dsp_ok;

  rd_src_e           src_d, src_q;
  logic [DATA_W-1:0] kbd_rd_d, kbd_rd_q;
  logic              kbd_rd_en;
  logic              dsp_ok_q;

  console_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  console_addr_dec #(
    .ADDR_W    (ADDR_W),
    .FB_DEPTH  (FB_DEPTH),
    .IDX_W     (IDX_W),
    .FB_BASE   (FB_BASE),
    .STAT_ADDR (STAT_ADDR),
    .CODE_ADDR (CODE_ADDR)
  ) u_dec (
    .addr     (bus_addr),
    .fb_hit   (fb_hit),
    .fb_idx   (fb_idx),
    .stat_hit (stat_hit),
    .code_hit (code_hit)
  );

  always_comb begin
    fb_wr   = bus_we & fb_hit;
    fb_rd   = bus_re & fb_hit;
    kbd_clr = bus_we & stat_hit & (bus_wdata == '0);
    dsp_ok  = (disp_addr < DEPTH_I);
  end

  console_text_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (FB_DEPTH),
    .IDX_W  (IDX_W)
  ) u_ram (
    .clk       (clk),
    .wr_en     (fb_wr),
    .wr_idx    (fb_idx),
    .wr_data   (bus_wdata),
    .cpu_rd_en (fb_rd),
    .cpu_idx   (fb_idx),
    .cpu_q     (text_q),
    .dsp_rd_en (dsp_ok),
    .dsp_idx   (disp_addr),
    .dsp_q     (dsp_q)
  );

  console_kbd_regs #(
    .DATA_W (DATA_W)
  ) u_kbd (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .strobe  (key_strobe),
    .code_in (key_code),
    .clr_req (kbd_clr),
    .flag_q  (kbd_stat),
    .code_q  (kbd_code)
  );

  // read-path next state
  always_comb begin
    src_d     = SRC_NONE;
    kbd_rd_en = bus_re & (stat_hit | code_hit);
    kbd_rd_d  = stat_hit ? DATA_W'(kbd_stat) : kbd_code;
    if (bus_re) begin
      if (fb_hit) begin
        src_d = SRC_TEXT;
      end else if (stat_hit || code_hit) begin
        src_d = SRC_KBD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      src_q    <= SRC_NONE;
      dsp_ok_q <= 1'b0;
    end else begin
      src_q    <= src_d;
      dsp_ok_q <= dsp_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      kbd_rd_q <= '0;
    end else if (kbd_rd_en) begin
      kbd_rd_q <= kbd_rd_d;
    end
  end

  always_comb begin
    case (src_q)
      SRC_TEXT: bus_rdata = text_q;
      SRC_KBD:  bus_rdata = kbd_rd_q;
      default:  bus_rdata = '0;
    endcase
    disp_rdata = dsp_ok_q ? dsp_q : '0;
  end

endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] FB_BASE   = 16'hF000,
  parameter logic [ADDR_W-1:0] FB_LAST   = 16'hF77F,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF800,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 16'hF801
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              key_strobe,
  input logic [DATA_W-1:0] key_code,
  input logic              kbd_stat,
  input logic [DATA_W-1:0] kbd_code
);

  logic clr_wr;
  logic unmapped;

  always_comb begin
    clr_wr   = bus_we && (bus_addr == STAT_ADDR) && (bus_wdata == '0);
    unmapped = !((bus_addr >= FB_BASE) && (bus_addr <= FB_LAST)) &&
               (bus_addr != STAT_ADDR) && (bus_addr != CODE_ADDR);
  end

  // R4
  key_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    key_strobe |=> (kbd_stat && (kbd_code == $past(key_code))));

  // R6
  key_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (key_strobe && clr_wr) |=> kbd_stat);

  // R5
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!key_strobe && clr_wr) |=> !kbd_stat);

  // R5
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!key_strobe && !clr_wr) |=> $stable(kbd_stat));

  // R7
  code_holds_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !key_strobe |=> $stable(kbd_code));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !bus_re |=> (bus_rdata == '0));

  // R8
  unmapped_rdata_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_re && unmapped) |=> (bus_rdata == '0));

  // R4
  flag_read_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_re && (bus_addr == STAT_ADDR)) |=> (bus_rdata == DATA_W'($past(kbd_stat))));

endmodule

bind console_mmio console_mmio_chk u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .key_strobe (key_strobe),
  .key_code   (key_code),
  .kbd_stat   (kbd_stat),
  .kbd_code   (kbd_code)
);

// File: tb/console_mmio_tb.sv
`timescale 1ns/1ps
module console_mmio_tb;

  localparam int NCELL = 1920;
  localparam logic [15:0] BASE = 16'hF000;
  localparam logic [15:0] STAT = 16'hF800;
  localparam logic [15:0] CODE = 16'hF801;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [7:0]  bus_rdata;
  logic        key_strobe;
  logic [7:0]  key_code;
  logic [10:0] disp_addr;
  logic [7:0]  disp_rdata;

  int total;
  int bad;
  logic [7:0] model [NCELL];

  console_mmio u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .key_strobe (key_strobe),
    .key_code   (key_code),
    .disp_addr  (disp_addr),
    .disp_rdata (disp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s * 91 + 11) & 255);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    check(req, bus_rdata, exp);
    bus_re = 1'b0;
  endtask

  task automatic dsp_rd(input logic [10:0] i, input logic [7:0] exp, input string req);
    @(negedge clk);
    disp_addr = i;
    @(negedge clk);
    check(req, disp_rdata, exp);
  endtask

  task automatic press(input logic [7:0] k);
    @(negedge clk);
    key_strobe = 1'b1; key_code = k;
    @(negedge clk);
    key_strobe = 1'b0;
  endtask

  task automatic collide(input int i, input logic [7:0] nv);
    @(negedge clk);
    bus_addr = BASE + 16'(i); bus_wdata = nv; bus_we = 1'b1; bus_re = 1'b1;
    disp_addr = 11'(i);
    @(negedge clk);
    check("R3 cpu old", bus_rdata, model[i]);
    check("R3 disp old", disp_rdata, model[i]);
    bus_we = 1'b0; bus_re = 1'b0;
    model[i] = nv;
    bus_rd(BASE + 16'(i), nv, "R3 cpu new");
    dsp_rd(11'(i), nv, "R3 disp new");
  endtask

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    key_strobe = 1'b0; key_code = '0; disp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset values
    bus_rd(STAT, 8'h00, "R10 flag");
    bus_rd(CODE, 8'h00, "R10 code");
    // R9: idle after read
    @(negedge clk);
    check("R9 idle rdata", bus_rdata, 8'h00);

    // R1: fill every cell at row*80+col
    for (int r = 0; r < 24; r++) begin
      for (int c = 0; c < 80; c++) begin
        model[r*80+c] = pat(r*80+c, 0);
        bus_wr(BASE + 16'(r*80+c), model[r*80+c]);
      end
    end
    for (int i = 0; i < NCELL; i++) dsp_rd(11'(i), model[i], "R1 display sweep");
    // R2: CPU read-back
    for (int i = 0; i < NCELL; i++) bus_rd(BASE + 16'(i), model[i], "R2 cpu sweep");
    @(negedge clk);
    check("R9 idle after sweep", bus_rdata, 8'h00);

    // R8: display indices past the end
    dsp_rd(11'd1920, 8'h00, "R8 disp 1920");
    dsp_rd(11'd2047, 8'h00, "R8 disp 2047");

    // R4 and R7
    press(8'h41);
    bus_rd(STAT, 8'h01, "R4 flag");
    bus_rd(CODE, 8'h41, "R4 code");
    press(8'h42);
    bus_rd(STAT, 8'h01, "R7 flag stays");
    bus_rd(CODE, 8'h42, "R7 code replaced");

    // R5: ignored writes
    bus_wr(STAT, 8'h05);
    bus_rd(STAT, 8'h01, "R5 nonzero flag write");
    bus_wr(CODE, 8'h77);
    bus_rd(CODE, 8'h42, "R5 code write");
    bus_wr(CODE, 8'h00);
    bus_rd(STAT, 8'h01, "R5 zero to code");

    // R8: unmapped writes and reads while flag is set
    bus_wr(16'hEFFF, 8'hAA);
    bus_wr(16'hF780, 8'hAA);
    bus_wr(16'hF7FF, 8'hAA);
    bus_wr(16'hF802, 8'h00);
    bus_wr(16'hFFFF, 8'h00);
    bus_wr(16'h0000, 8'hAA);
    bus_rd(16'hEFFF, 8'h00, "R8 read EFFF");
    bus_rd(16'hF780, 8'h00, "R8 read F780");
    bus_rd(16'hF7FF, 8'h00, "R8 read F7FF");
    bus_rd(16'hF802, 8'h00, "R8 read F802");
    bus_rd(16'hFFFF, 8'h00, "R8 read FFFF");
    bus_rd(16'h0000, 8'h00, "R8 read 0000");
    bus_rd(BASE, model[0], "R8 first cell intact");
    bus_rd(BASE + 16'(NCELL-1), model[NCELL-1], "R8 last cell intact");
    dsp_rd(11'(NCELL-1), model[NCELL-1], "R8 last cell disp");
    bus_rd(STAT, 8'h01, "R8 flag intact");
    bus_rd(CODE, 8'h42, "R8 code intact");

    // R5: clear, then nonzero write keeps it clear
    bus_wr(STAT, 8'h00);
    bus_rd(STAT, 8'h00, "R5 clear");
    bus_wr(STAT, 8'h01);
    bus_rd(STAT, 8'h00, "R5 nonzero write while clear");

    // R6: strobe and clear on the same edge
    @(negedge clk);
    key_strobe = 1'b1; key_code = 8'h5A;
    bus_addr = STAT; bus_wdata = 8'h00; bus_we = 1'b1;
    @(negedge clk);
    key_strobe = 1'b0; bus_we = 1'b0;
    bus_rd(STAT, 8'h01, "R6 flag");
    bus_rd(CODE, 8'h5A, "R6 code");
    bus_wr(STAT, 8'h00);

    // R4 R5: every key code through set and acknowledge
    for (int k = 0; k < 256; k++) begin
      press(8'(k));
      bus_rd(CODE, 8'(k), "R4 code sweep");
      bus_rd(STAT, 8'h01, "R4 flag sweep");
      bus_wr(STAT, 8'h00);
      bus_rd(STAT, 8'h00, "R5 ack sweep");
    end

    // R3: write and reads of one cell on the same edge
    collide(0, 8'hC3);
    collide(79, 8'h3C);
    collide(80, 8'h99);
    collide(NCELL-1, 8'h5F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule